// File: doc/BRIEF.md
# Unaligned Partial-Word Load/Store Merge Unit

This unit performs the byte-lane merging behind the left and right partial-word loads and stores of a 32-bit in-order core. Each accepted operation is one instruction slot. A partial load combines the aligned memory word with the current value of its destination register. A partial store combines the aligned memory word with a source register and emits the word that goes back to the aligned address. Address generation and the memory bus are not part of the unit: the caller supplies the aligned word and the two low address bits.

The unit owns the register file and the one-entry load-delay slot. A load result is parked in the slot and reaches the register file only when the next operation is accepted. A partial load whose destination matches the parked load merges with the parked value instead of the stored register. A second load to the same register discards the parked value without writing it.

Operations enter over a valid/ready port. Store results leave over a valid/ready port that holds one word. While a store word is waiting (`st_valid` high, `st_ready` low), `op_ready` is low and no new operation is taken. The word and its valid flag stay unchanged until the handshake completes. A debug read port (`rd_sel`/`rd_data`) shows register contents combinationally.

Top module: `umerge_unit`

## Requirements
- R1: Load-right (kind 4) with byte offset o yields the memory word shifted right by 8*o bits. Its upper o bytes keep the old destination value: o=0 gives mem, o=1 gives (old&0xFF000000)|(mem>>8), o=2 gives (old&0xFFFF0000)|(mem>>16), o=3 gives (old&0xFFFFFF00)|(mem>>24).
- R2: Load-left (kind 3) yields mem<<24 with old low 3 bytes at o=0, mem<<16 with old low 2 bytes at o=1, and mem<<8 with old low byte at o=2. At o=3 it yields mem.
- R3: Store-right (kind 6) emits the source register at o=0. At o=1 it emits (mem&0xFF)|(reg<<8), at o=2 (mem&0xFFFF)|(reg<<16), and at o=3 (mem&0xFFFFFF)|(reg<<24).
- R4: Store-left (kind 5) emits (mem&0xFFFFFF00)|(reg>>24) at o=0, (mem&0xFFFF0000)|(reg>>16) at o=1 and (mem&0xFF000000)|(reg>>8) at o=2. At o=3 it emits the register.
- R5: Word load (kind 2) yields the memory word unchanged, whatever the offset.
- R6: A load result is not in the register file after its own operation. It is written when the next operation is accepted.
- R7: A partial load whose destination equals the parked load's register takes the parked data, not the register file value, as its old value.
- R8: A load whose destination equals the parked load's register drops the parked value, so that value is never written.
- R9: Register 0 always reads zero. Register writes (kind 1) and loads that target it have no effect.
- R10: A store reads its source from the register file, so a load parked in the delay slot is not visible to it.
- R11: A register write (kind 1, value on `op_word`) takes effect at its own acceptance. When a parked load to the same register retires in that same cycle, the register write wins.
- R12: While `st_valid` is high and `st_ready` low, `st_valid` stays high, `st_word` is stable and `op_ready` is low.
- R13: A no-op (kind 0) or the reserved kind 7 only retires the delay slot. It raises no store word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be accepted |
| op_kind | input | 3 | 0 no-op, 1 register write, 2 word load, 3 load-left, 4 load-right, 5 store-left, 6 store-right, 7 reserved |
| op_ofs | input | 2 | Low address bits (byte offset) |
| op_reg | input | 5 | Destination (loads, writes) or source (stores) register |
| op_word | input | 32 | Aligned memory word, or the value for a register write |
| st_valid | output | 1 | Store word available |
| st_ready | input | 1 | Consumer takes the store word |
| st_word | output | 32 | Merged word for the aligned address |
| rd_sel | input | 5 | Debug read register index |
| rd_data | output | 32 | Debug read register value |

## Verification
The bench sweeps all four offsets of each partial operation against a register value and a memory word whose bytes all differ. A reversed lane mask or an off-by-one shift therefore shows up as a wrong byte. It tests load forwarding with a word load followed by a partial load to the same register. A design that merged with the register file would keep stale upper or lower bytes. A back-to-back pair of loads to one register checks that the first value is dropped rather than briefly written. Other tests probe the store path during a parked load, which a forwarding store would get wrong, and a stalled store output, where a leaky design would lose or change the word.

// File: rtl/umerge_pkg.sv
package umerge_pkg;

  typedef enum logic [2:0] {
    OPK_NOP     = 3'd0,
    OPK_REGWR   = 3'd1,
    OPK_LDWORD  = 3'd2,
    OPK_LDLEFT  = 3'd3,
    OPK_LDRIGHT = 3'd4,
    OPK_STLEFT  = 3'd5,
    OPK_STRIGHT = 3'd6,
    OPK_RSVD    = 3'd7
  } op_kind_e;

  function automatic logic kind_is_load(input op_kind_e k);
    return (k == OPK_LDWORD) || (k == OPK_LDLEFT) || (k == OPK_LDRIGHT);
  endfunction

  function automatic logic kind_is_store(input op_kind_e k);
    return (k == OPK_STLEFT) || (k == OPK_STRIGHT);
  endfunction

endpackage

// File: rtl/umerge_lanes.sv
module umerge_lanes
  import umerge_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int OFS_W = $clog2(NBYTES),
  localparam int DW    = NBYTES * 8
) (
  input  op_kind_e          kind,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DW-1:0]     keep_word,
  input  logic [DW-1:0]     src_word,
  output logic [DW-1:0]     res_word
);

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic             take;
    int               idx;
    logic [OFS_W-1:0] idx_t;
    int               o;

    always_comb begin
      o    = int'(ofs);
      take = 1'b0;
      idx  = i;
      case (kind)
        OPK_LDWORD: begin
          take = 1'b1;
          idx  = i;
        end
        OPK_LDLEFT: begin
          take = (i >= NBYTES - 1 - o);
          idx  = i - (NBYTES - 1 - o);
        end
        OPK_LDRIGHT: begin
          take = (i <= NBYTES - 1 - o);
          idx  = i + o;
        end
        OPK_STRIGHT: begin
          take = (i >= o);
          idx  = i - o;
        end
        OPK_STLEFT: begin
          take = (i <= o);
          idx  = i + NBYTES - 1 - o;
        end
        default: begin
          take = 1'b0;
          idx  = i;
        end
      endcase
      idx_t = OFS_W'(idx);
    end

    assign res_word[i*8 +: 8] = take ? src_word[idx_t*8 +: 8]
                                     : keep_word[i*8 +: 8];
  end

endmodule

// File: rtl/umerge_regfile.sv
module umerge_regfile #(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wa_en,
  input  logic [IW-1:0] wa_idx,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data
);

  logic [DW-1:0] regs [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign regs[r] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          regs[r] <= '0;
        end else if (wb_en && wb_idx == IW'(r)) begin
          regs[r] <= wb_data;
        end else if (wa_en && wa_idx == IW'(r)) begin
          regs[r] <= wa_data;
        end
      end
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

endmodule

// File: rtl/umerge_delay_slot.sv
module umerge_delay_slot #(
  parameter int DW = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          new_load,
  input  logic [IW-1:0] new_reg,
  input  logic [DW-1:0] new_data,
  input  logic [IW-1:0] probe_reg,
  output logic          fwd_hit,
  output logic [DW-1:0] fwd_data,
  output logic          retire_en,
  output logic [IW-1:0] retire_reg,
  output logic [DW-1:0] retire_data
);

  logic          pend_v;
  logic [IW-1:0] pend_reg;
  logic [DW-1:0] pend_data;
  logic          superseded;

  assign fwd_hit    = pend_v && (pend_reg == probe_reg);
  assign fwd_data   = pend_data;
  assign superseded = new_load && (new_reg == pend_reg);
  assign retire_en  = advance && pend_v && !superseded;
  assign retire_reg = pend_reg;
  assign retire_data = pend_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_reg  <= '0;
      pend_data <= '0;
    end else if (advance) begin
      pend_v <= new_load;
      if (new_load) begin
        pend_reg  <= new_reg;
        pend_data <= new_data;
      end
    end
  end

endmodule

// File: rtl/umerge_unit.sv
module umerge_unit
  import umerge_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int NREGS  = 32,
  localparam int DW    = NBYTES * 8,
  localparam int OFS_W = $clog2(NBYTES),
  localparam int IW    = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [2:0]       op_kind,
  input  logic [OFS_W-1:0] op_ofs,
  input  logic [IW-1:0]    op_reg,
  input  logic [DW-1:0]    op_word,
  output logic             st_valid,
  input  logic             st_ready,
  output logic [DW-1:0]    st_word,
  input  logic [IW-1:0]    rd_sel,
  output logic [DW-1:0]    rd_data
);

  op_kind_e      kind;
  logic          fire;
  logic          is_load;
  logic          is_store;
  logic          is_regwr;
  logic          load_live;
  logic [DW-1:0] rf_val;
  logic          fwd_hit;
  logic [DW-1:0] fwd_data;
  logic [DW-1:0] old_val;
  logic [DW-1:0] keep_w;
  logic [DW-1:0] src_w;
  logic [DW-1:0] merged;
  logic          ret_en;
  logic [IW-1:0] ret_reg;
  logic [DW-1:0] ret_data;

  assign kind      = op_kind_e'(op_kind);
  assign op_ready  = !st_valid || st_ready;
  assign fire      = op_valid && op_ready;
  assign is_load   = kind_is_load(kind);
  assign is_store  = kind_is_store(kind);
  assign is_regwr  = (kind == OPK_REGWR);
  assign load_live = fire && is_load && (op_reg != '0);

  // Old destination value: the parked load wins over the stored register.
  assign old_val = fwd_hit ? fwd_data : rf_val;
  // Loads keep old bytes and take memory bytes; stores the reverse.
  assign keep_w  = is_store ? op_word : old_val;
  assign src_w   = is_store ? rf_val  : op_word;

  umerge_lanes #(.NBYTES(NBYTES)) u_lanes (
    .kind      (kind),
    .ofs       (op_ofs),
    .keep_word (keep_w),
    .src_word  (src_w),
    .res_word  (merged)
  );

  umerge_delay_slot #(.DW(DW), .IW(IW)) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (fire),
    .new_load    (load_live),
    .new_reg     (op_reg),
    .new_data    (merged),
    .probe_reg   (op_reg),
    .fwd_hit     (fwd_hit),
    .fwd_data    (fwd_data),
    .retire_en   (ret_en),
    .retire_reg  (ret_reg),
    .retire_data (ret_data)
  );

  umerge_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (ret_en),
    .wa_idx  (ret_reg),
    .wa_data (ret_data),
    .wb_en   (fire && is_regwr),
    .wb_idx  (op_reg),
    .wb_data (op_word),
    .ra_idx  (op_reg),
    .ra_data (rf_val),
    .rb_idx  (rd_sel),
    .rb_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_word  <= '0;
    end else if (fire) begin
      st_valid <= is_store;
      if (is_store) st_word <= merged;
    end else if (st_ready) begin
      st_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/umerge_checks.sv
module umerge_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        op_ready,
  input logic [2:0]  op_kind,
  input logic        st_valid,
  input logic        st_ready,
  input logic [31:0] st_word,
  input logic [4:0]  rd_sel,
  input logic [31:0] rd_data
);

  logic fire_st, fire_other;
  assign fire_st    = op_valid && op_ready && (op_kind == 3'd5 || op_kind == 3'd6);
  assign fire_other = op_valid && op_ready && !(op_kind == 3'd5 || op_kind == 3'd6);

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_word)));

  p_stall_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> !op_ready);

  p_store_emits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_st |=> st_valid);

  p_nonstore_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fire_other |=> !st_valid);

  p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 5'd0) |-> (rd_data == 32'd0));

endmodule

bind umerge_unit umerge_checks u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_kind  (op_kind),
  .st_valid (st_valid),
  .st_ready (st_ready),
  .st_word  (st_word),
  .rd_sel   (rd_sel),
  .rd_data  (rd_data)
);

// File: tb/umerge_unit_test.sv
module umerge_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_kind = 3'd0;
  logic [1:0]  op_ofs = 2'd0;
  logic [4:0]  op_reg = 5'd0;
  logic [31:0] op_word = 32'd0;
  logic        st_valid;
  logic        st_ready = 1'b1;
  logic [31:0] st_word;
  logic [4:0]  rd_sel = 5'd0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  umerge_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_ofs(op_ofs), .op_reg(op_reg), .op_word(op_word),
    .st_valid(st_valid), .st_ready(st_ready), .st_word(st_word),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  localparam logic [31:0] OLDV = 32'hA1B2C3D4;
  localparam logic [31:0] MEMV = 32'h15263748;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_lr(input logic [31:0] old, input logic [31:0] m, input int o);
    case (o)
      0: return m;
      1: return (old & 32'hFF000000) | (m >> 8);
      2: return (old & 32'hFFFF0000) | (m >> 16);
      default: return (old & 32'hFFFFFF00) | (m >> 24);
    endcase
  endfunction

  function automatic logic [31:0] m_ll(input logic [31:0] old, input logic [31:0] m, input int o);
    case (o)
      0: return (old & 32'h00FFFFFF) | (m << 24);
      1: return (old & 32'h0000FFFF) | (m << 16);
      2: return (old & 32'h000000FF) | (m << 8);
      default: return m;
    endcase
  endfunction

  function automatic logic [31:0] m_sr(input logic [31:0] m, input logic [31:0] r, input int o);
    case (o)
      0: return r;
      1: return (m & 32'hFF) | (r << 8);
      2: return (m & 32'hFFFF) | (r << 16);
      default: return (m & 32'hFFFFFF) | (r << 24);
    endcase
  endfunction

  function automatic logic [31:0] m_sl(input logic [31:0] m, input logic [31:0] r, input int o);
    case (o)
      0: return (m & 32'hFFFFFF00) | (r >> 24);
      1: return (m & 32'hFFFF0000) | (r >> 16);
      2: return (m & 32'hFF000000) | (r >> 8);
      default: return r;
    endcase
  endfunction

  // Called at a negedge; returns at the negedge after acceptance.
  task automatic do_op(input logic [2:0] k, input int o, input logic [4:0] r, input logic [31:0] w);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_ofs = 2'(o); op_reg = r; op_word = w;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic logic [31:0] peek(input logic [4:0] r);
    rd_sel = r;
    return rd_data;
  endfunction

  task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
    rd_sel = r;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    read_reg(5'd5, v); chk("reset reg5", v, 32'd0);
    read_reg(5'd31, v); chk("reset reg31", v, 32'd0);
    chk("reset st_valid", {31'd0, st_valid}, 32'd0);
    chk("reset op_ready", {31'd0, op_ready}, 32'd1);
  endtask

  task automatic t_load_right_r1;
    logic [31:0] v;
    for (int o = 0; o < 4; o++) begin
      do_op(3'd1, 0, 5'd5, OLDV);
      do_op(3'd4, o, 5'd5, MEMV);
      do_op(3'd0, 0, 5'd0, 32'd0);
      read_reg(5'd5, v);
      chk($sformatf("R1 load-right ofs %0d", o), v, m_lr(OLDV, MEMV, o));
    end
  endtask

  task automatic t_load_left_r2;
    logic [31:0] v;
    for (int o = 0; o < 4; o++) begin
      do_op(3'd1, 0, 5'd6, OLDV);
      do_op(3'd3, o, 5'd6, MEMV);
      do_op(3'd0, 0, 5'd0, 32'd0);
      read_reg(5'd6, v);
      chk($sformatf("R2 load-left ofs %0d", o), v, m_ll(OLDV, MEMV, o));
    end
  endtask

  task automatic t_stores_r3_r4;
    do_op(3'd1, 0, 5'd7, OLDV);
    for (int o = 0; o < 4; o++) begin
      do_op(3'd6, o, 5'd7, MEMV);
      chk($sformatf("R3 store-right ofs %0d", o), st_word, m_sr(MEMV, OLDV, o));
      do_op(3'd5, o, 5'd7, MEMV);
      chk($sformatf("R4 store-left ofs %0d", o), st_word, m_sl(MEMV, OLDV, o));
    end
    @(negedge clk);
  endtask

  task automatic t_word_and_delay_r5_r6;
    logic [31:0] v;
    do_op(3'd1, 0, 5'd9, OLDV);
    do_op(3'd2, 3, 5'd9, MEMV);
    read_reg(5'd9, v); chk("R6 load not visible yet", v, OLDV);
    do_op(3'd0, 0, 5'd0, 32'd0);
    read_reg(5'd9, v); chk("R5 word load ofs 3", v, MEMV);
  endtask

  task automatic t_forward_r7;
    logic [31:0] v;
    do_op(3'd1, 0, 5'd10, 32'h0);
    do_op(3'd2, 0, 5'd10, 32'hCAFEF00D);
    do_op(3'd4, 1, 5'd10, MEMV);
    do_op(3'd0, 0, 5'd0, 32'd0);
    read_reg(5'd10, v);
    chk("R7 load-right merges parked data", v, m_lr(32'hCAFEF00D, MEMV, 1));
    do_op(3'd2, 0, 5'd11, 32'h89ABCDEF);
    do_op(3'd3, 2, 5'd11, MEMV);
    do_op(3'd0, 0, 5'd0, 32'd0);
    read_reg(5'd11, v);
    chk("R7 load-left merges parked data", v, m_ll(32'h89ABCDEF, MEMV, 2));
  endtask

  task automatic t_drop_r8;
    logic [31:0] v;
    do_op(3'd1, 0, 5'd12, 32'h11111111);
    do_op(3'd2, 0, 5'd12, 32'h22222222);
    do_op(3'd2, 0, 5'd12, 32'h33333333);
    read_reg(5'd12, v); chk("R8 first load dropped", v, 32'h11111111);
    do_op(3'd0, 0, 5'd0, 32'd0);
    read_reg(5'd12, v); chk("R8 second load lands", v, 32'h33333333);
  endtask

  task automatic t_zero_r9;
    logic [31:0] v;
    do_op(3'd1, 0, 5'd0, 32'hFFFFFFFF);
    read_reg(5'd0, v); chk("R9 write to reg0 ignored", v, 32'd0);
    do_op(3'd2, 0, 5'd0, 32'h12345678);
    do_op(3'd0, 0, 5'd0, 32'd0);
    read_reg(5'd0, v); chk("R9 load to reg0 ignored", v, 32'd0);
  endtask

  task automatic t_store_no_fwd_r10;
    do_op(3'd1, 0, 5'd13, 32'h0BADBEEF);
    do_op(3'd2, 0, 5'd13, 32'h55AA55AA);
    do_op(3'd6, 0, 5'd13, MEMV);
    chk("R10 store reads register file", st_word, 32'h0BADBEEF);
    @(negedge clk);
  endtask

  task automatic t_regwr_wins_r11;
    logic [31:0] v;
    do_op(3'd2, 0, 5'd14, 32'h44444444);
    do_op(3'd1, 0, 5'd14, 32'h77777777);
    read_reg(5'd14, v); chk("R11 register write wins", v, 32'h77777777);
    do_op(3'd0, 0, 5'd0, 32'd0);
    read_reg(5'd14, v); chk("R11 value kept after no-op", v, 32'h77777777);
  endtask

  task automatic t_stall_r12;
    logic [31:0] first;
    do_op(3'd1, 0, 5'd15, OLDV);
    st_ready = 1'b0;
    do_op(3'd6, 2, 5'd15, MEMV);
    first = st_word;
    chk("R12 store word", first, m_sr(MEMV, OLDV, 2));
    repeat (3) @(negedge clk);
    chk("R12 held valid", {31'd0, st_valid}, 32'd1);
    chk("R12 word stable", st_word, first);
    chk("R12 op_ready low", {31'd0, op_ready}, 32'd0);
    st_ready = 1'b1;
    @(negedge clk);
    chk("R12 cleared after handshake", {31'd0, st_valid}, 32'd0);
  endtask

  task automatic t_nop_r13;
    logic [31:0] v;
    do_op(3'd2, 0, 5'd16, 32'hDEADC0DE);
    do_op(3'd7, 1, 5'd16, 32'h0);
    chk("R13 reserved kind raises no store", {31'd0, st_valid}, 32'd0);
    read_reg(5'd16, v); chk("R13 reserved kind retires slot", v, 32'hDEADC0DE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_right_r1();
    t_load_left_r2();
    t_stores_r3_r4();
    t_word_and_delay_r5_r6();
    t_forward_r7();
    t_drop_r8();
    t_zero_r9();
    t_store_no_fwd_r10();
    t_regwr_wins_r11();
    t_stall_r12();
    t_nop_r13();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule